// File: doc/BRIEF.md
# Encoded-Ratio Controller Clock Divider

This block derives the clock for a controller from a faster source clock. A 3-bit select picks one of eight divide ratios from a fixed set that is not evenly spaced: 1, 2, 4, 6, 8, 16, 24 or 32. A separate synchronous divider reset must be held while the select changes. The new ratio is captured only during that reset, and it takes effect when the reset is released. The divided output appears only while the clock enable is set. A bypass select can route a clock from outside the chip to the output in place of the divided source.

Configuration software normally picks the smallest ratio that brings the source frequency into the 150 to 300 MHz band. It then asserts the divider reset, writes the select and the enable, and reads back the applied ratio code and the enable state to confirm the setting before it releases the reset. All control inputs are registered in the source clock domain before use, so every control change lands one source cycle later than its input. The control pins are plain level signals with no handshake.

Top module: `ctlclk_div`

## Requirements
- R1: Select codes 0..7 give ratios 1, 2, 4, 6, 8, 16, 24, 32. For every even ratio N the output is low for N/2 source cycles and then high for N/2 source cycles, which is a 50% duty cycle.
- R2: With code 0 applied, enable set and the divider reset released, the output follows the source clock: it is high in the high phase of the source clock and low in the low phase.
- R3: The applied ratio code follows the registered select only while the registered divider reset is high. A change of `ratio_sel_i` while the divider reset is low does not change `ratio_code_o` or the output period.
- R4: While the divider reset is held and the bypass select is 0, the output is low. After the reset is released, the first high phase starts only after a full low half-period of N/2 source cycles, counted from the first source edge that sees the released reset. No runt pulse is produced.
- R5: When the enable is low, the output is low on both the divided path and the bypass path.
- R6: When the bypass select is 1, the output equals `clk_ext_i` gated by the enable. The divider reset has no effect on this path.
- R7: `clk_en_o` shows `clk_en_i` one source cycle later. `ratio_code_o` shows a select that was written under the divider reset two source cycles after both inputs were applied.
- R8: The asynchronous reset `rst_n_i` low clears the output, the applied code (to 0) and the enable status (to 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src_i | input | 1 | Source (coprocessor) clock |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| clk_ext_i | input | 1 | External bypass clock |
| ratio_sel_i | input | 3 | Encoded divide ratio select |
| div_rst_i | input | 1 | Synchronous divider reset, active high |
| clk_en_i | input | 1 | Output clock enable |
| byp_sel_i | input | 1 | 0 = divided source, 1 = external clock |
| clk_ctl_o | output | 1 | Controller clock |
| ratio_code_o | output | 3 | Applied ratio code readback |
| clk_en_o | output | 1 | Applied enable readback |

## Verification
The assertions check these properties on every source cycle:
- The applied code stays fixed whenever the divider reset is low.
- The divided toggle is cleared one cycle after the divider reset.
- The half-period counter never passes its limit for the applied code.
- The output stays low one cycle into any period in which the enable is low.
- The enable readback follows its input with one cycle of delay.

Only the bench scenarios can show the rest:
- the exact low and high run lengths for each of the eight ratios;
- the absence of a runt pulse after release;
- the pass-through of the source clock at ratio 1;
- the bypass output following the external clock while the divider reset is held.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int SEL_W     = 3;
  localparam int MAX_RATIO = 32;
  localparam int CNT_W     = $clog2(MAX_RATIO / 2);
  localparam int HALF_W    = CNT_W + 1;

  typedef logic [SEL_W-1:0]  sel_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [HALF_W-1:0] half_t;

  // full divide ratio for an encoded select
  function automatic int unsigned ratio_of(sel_t code);
    case (code)
      3'd0:    ratio_of = 1;
      3'd1:    ratio_of = 2;
      3'd2:    ratio_of = 4;
      3'd3:    ratio_of = 6;
      3'd4:    ratio_of = 8;
      3'd5:    ratio_of = 16;
      3'd6:    ratio_of = 24;
      default: ratio_of = 32;
    endcase
  endfunction

  // source cycles per output half-period (ratio 1 uses 1, counter idles)
  function automatic half_t half_of(sel_t code);
    int unsigned r;
    r = ratio_of(code);
    half_of = (r < 2) ? half_t'(1) : half_t'(r / 2);
  endfunction
endpackage

// File: rtl/clkdiv_inreg.sv
module clkdiv_inreg
  import clkdiv_pkg::*;
#(
  parameter int W = SEL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sel_i,
  input  logic         div_rst_i,
  input  logic         en_i,
  input  logic         byp_i,
  output logic [W-1:0] code_q,
  output logic         div_rst_q,
  output logic         en_q,
  output logic         byp_q
);
  logic [W-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      div_rst_q <= 1'b0;
      en_q      <= 1'b0;
      byp_q     <= 1'b0;
    end else begin
      sel_q     <= sel_i;
      div_rst_q <= div_rst_i;
      en_q      <= en_i;
      byp_q     <= byp_i;
    end
  end

  // applied code only moves while the divider is held in reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         code_q <= '0;
    else if (div_rst_q) code_q <= sel_q;
  end
endmodule

// File: rtl/clkdiv_count.sv
module clkdiv_count
  import clkdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic div_rst_q,
  input  sel_t code_q,
  output logic tog_o,
  output cnt_t cnt_o
);
  half_t half;
  logic  wrap;

  always_comb begin
    half = half_of(code_q);
    wrap = ({1'b0, cnt_o} == (half - half_t'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      tog_o <= 1'b0;
    end else if (div_rst_q) begin
      cnt_o <= '0;
      tog_o <= 1'b0;
    end else if (wrap) begin
      cnt_o <= '0;
      tog_o <= ~tog_o;
    end else begin
      cnt_o <= cnt_o + cnt_t'(1);
    end
  end
endmodule

// File: rtl/clkdiv_outsel.sv
module clkdiv_outsel
  import clkdiv_pkg::*;
(
  input  logic clk_src,
  input  logic clk_ext,
  input  logic rst_n,
  input  sel_t code_q,
  input  logic div_rst_q,
  input  logic en_q,
  input  logic byp_q,
  input  logic tog,
  output logic clk_o
);
  logic pass_run;
  logic pass_gate;
  logic pass_clk;
  logic div_clk;
  logic ext_clk;

  assign pass_run = en_q & ~div_rst_q & (code_q == '0);

  // gate updated in the low phase so the pass-through never clips a pulse
  always_ff @(negedge clk_src or negedge rst_n) begin
    if (!rst_n) pass_gate <= 1'b0;
    else        pass_gate <= pass_run;
  end

  always_comb begin
    pass_clk = clk_src & pass_gate;
    div_clk  = tog & en_q & ~div_rst_q;
    ext_clk  = clk_ext & en_q;
    if (byp_q)               clk_o = ext_clk;
    else if (code_q == '0)   clk_o = pass_clk;
    else                     clk_o = div_clk;
  end
endmodule

// File: rtl/ctlclk_div.sv
module ctlclk_div
  import clkdiv_pkg::*;
(
  input  logic             clk_src_i,
  input  logic             rst_n_i,
  input  logic             clk_ext_i,
  input  logic [SEL_W-1:0] ratio_sel_i,
  input  logic             div_rst_i,
  input  logic             clk_en_i,
  input  logic             byp_sel_i,
  output logic             clk_ctl_o,
  output logic [SEL_W-1:0] ratio_code_o,
  output logic             clk_en_o
);
  sel_t code_q;
  logic div_rst_q;
  logic en_q;
  logic byp_q;
  logic tog;
  cnt_t cnt;

  clkdiv_inreg #(.W(SEL_W)) u_inreg (
    .clk       (clk_src_i),
    .rst_n     (rst_n_i),
    .sel_i     (ratio_sel_i),
    .div_rst_i (div_rst_i),
    .en_i      (clk_en_i),
    .byp_i     (byp_sel_i),
    .code_q    (code_q),
    .div_rst_q (div_rst_q),
    .en_q      (en_q),
    .byp_q     (byp_q)
  );

  clkdiv_count u_count (
    .clk       (clk_src_i),
    .rst_n     (rst_n_i),
    .div_rst_q (div_rst_q),
    .code_q    (code_q),
    .tog_o     (tog),
    .cnt_o     (cnt)
  );

  clkdiv_outsel u_outsel (
    .clk_src   (clk_src_i),
    .clk_ext   (clk_ext_i),
    .rst_n     (rst_n_i),
    .code_q    (code_q),
    .div_rst_q (div_rst_q),
    .en_q      (en_q),
    .byp_q     (byp_q),
    .tog       (tog),
    .clk_o     (clk_ctl_o)
  );

  assign ratio_code_o = code_q;
  assign clk_en_o     = en_q;
endmodule

// File: rtl/ctlclk_div_chk.sv
module ctlclk_div_chk
  import clkdiv_pkg::*;
(
  input logic clk_src,
  input logic rst_n,
  input logic en_in,
  input logic en_stat,
  input sel_t code,
  input logic div_rst_q,
  input logic byp_q,
  input logic tog,
  input cnt_t cnt,
  input logic clk_out
);
  // R3: applied code frozen while divider reset is low
  assert_code_hold_R3: assert property (@(posedge clk_src) disable iff (!rst_n)
    !div_rst_q |=> $stable(code));

  // R4: toggle cleared one cycle after divider reset seen
  assert_tog_clear_R4: assert property (@(posedge clk_src) disable iff (!rst_n)
    div_rst_q |=> !tog);

  // R1: half-period counter stays below its limit
  assert_cnt_bound_R1: assert property (@(posedge clk_src) disable iff (!rst_n)
    ({1'b0, cnt} < half_of(code)));

  // R5: disabled output is low by the next low-going edge
  assert_gate_low_R5: assert property (@(negedge clk_src) disable iff (!rst_n)
    !$past(en_stat) |=> ($past(en_stat) || !clk_out));

  // R7: enable readback trails its input by one cycle
  assert_en_status_R7: assert property (@(posedge clk_src) disable iff (!rst_n)
    1'b1 |=> (en_stat == $past(en_in)));

  // R6: bypass with enable low keeps output low
  assert_byp_off_R6: assert property (@(negedge clk_src) disable iff (!rst_n)
    (byp_q && !en_stat) |-> !clk_out);
endmodule

bind ctlclk_div ctlclk_div_chk u_chk (
  .clk_src   (clk_src_i),
  .rst_n     (rst_n_i),
  .en_in     (clk_en_i),
  .en_stat   (clk_en_o),
  .code      (code_q),
  .div_rst_q (div_rst_q),
  .byp_q     (byp_q),
  .tog       (tog),
  .cnt       (cnt),
  .clk_out   (clk_ctl_o)
);

// File: tb/tb_ctlclk_div.sv
`timescale 1ns/1ps
module tb_ctlclk_div;
  logic       clk_src = 1'b0;
  logic       clk_ext = 1'b0;
  logic       rst_n   = 1'b0;
  logic [2:0] sel     = 3'd0;
  logic       div_rst = 1'b1;
  logic       en      = 1'b0;
  logic       byp     = 1'b0;
  logic       clk_ctl;
  logic [2:0] code_o;
  logic       en_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk_src = ~clk_src;
  always #7   clk_ext = ~clk_ext;

  ctlclk_div dut (
    .clk_src_i    (clk_src),
    .rst_n_i      (rst_n),
    .clk_ext_i    (clk_ext),
    .ratio_sel_i  (sel),
    .div_rst_i    (div_rst),
    .clk_en_i     (en),
    .byp_sel_i    (byp),
    .clk_ctl_o    (clk_ctl),
    .ratio_code_o (code_o),
    .clk_en_o     (en_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int half_exp(input int code);
    int r[8] = '{1, 2, 4, 6, 8, 16, 24, 32};
    return r[code] / 2;
  endfunction

  // R8: reset state
  task automatic t_reset();
    #1;
    check(clk_ctl == 1'b0, "R8 out", clk_ctl, 0);
    check(code_o == 3'd0,  "R8 code", code_o, 0);
    check(en_o == 1'b0,    "R8 en", en_o, 0);
  endtask

  // R7: readback latency, then R1/R4 waveform from release
  task automatic t_ratio(input int code);
    int h, errs, exp_v;
    h = half_exp(code);
    @(negedge clk_src);
    div_rst = 1'b1; sel = 3'(code); en = 1'b1; byp = 1'b0;
    @(negedge clk_src); #0.5;
    check(en_o == 1'b1, "R7 en readback", en_o, 1);
    @(negedge clk_src); #0.5;
    check(code_o == 3'(code), "R7 code readback", code_o, code);
    check(clk_ctl == 1'b0, "R4 low under divider reset", clk_ctl, 0);
    @(negedge clk_src);
    div_rst = 1'b0;
    errs = 0;
    for (int k = 1; k <= 3 * h; k++) begin
      @(negedge clk_src); #0.5;
      exp_v = ((k - 1) / h) % 2;
      if (clk_ctl !== 1'(exp_v)) errs++;
    end
    check(errs == 0, $sformatf("R1 R4 waveform ratio code %0d", code), errs, 0);
  endtask

  // R2: ratio 1 pass-through
  task automatic t_pass();
    int errs = 0;
    @(negedge clk_src);
    div_rst = 1'b1; sel = 3'd0; en = 1'b1; byp = 1'b0;
    repeat (3) @(negedge clk_src);
    div_rst = 1'b0;
    repeat (3) @(negedge clk_src);
    for (int k = 0; k < 6; k++) begin
      @(posedge clk_src); #1;
      if (clk_ctl !== 1'b1) errs++;
      @(negedge clk_src); #1;
      if (clk_ctl !== 1'b0) errs++;
    end
    check(errs == 0, "R2 pass-through", errs, 0);
  endtask

  // R3: select change without divider reset is ignored
  task automatic t_ignore_sel();
    int ones = 0;
    t_ratio(3);
    @(negedge clk_src);
    sel = 3'd5;
    repeat (4) @(negedge clk_src);
    #0.5;
    check(code_o == 3'd3, "R3 code held", code_o, 3);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk_src); #0.5;
      if (clk_ctl) ones++;
    end
    check(ones == 3, "R3 period unchanged", ones, 3);
  endtask

  // R5: enable low forces output low
  task automatic t_enable_off();
    int errs = 0;
    t_ratio(1);
    @(negedge clk_src);
    en = 1'b0;
    repeat (2) @(negedge clk_src);
    for (int k = 0; k < 10; k++) begin
      @(posedge clk_src); #1;
      if (clk_ctl !== 1'b0) errs++;
      @(negedge clk_src); #1;
      if (clk_ctl !== 1'b0) errs++;
    end
    check(errs == 0, "R5 divided path off", errs, 0);
    check(en_o == 1'b0, "R5 en readback", en_o, 0);
  endtask

  // R6: bypass follows external clock, ignores divider reset
  task automatic t_bypass();
    int errs = 0;
    @(negedge clk_src);
    div_rst = 1'b1; byp = 1'b1; en = 1'b1; sel = 3'd2;
    repeat (3) @(negedge clk_src);
    for (int k = 0; k < 10; k++) begin
      @(clk_ext); #1;
      if (clk_ctl !== clk_ext) errs++;
    end
    check(errs == 0, "R6 bypass follows external", errs, 0);
    @(negedge clk_src);
    en = 1'b0;
    repeat (3) @(negedge clk_src);
    errs = 0;
    for (int k = 0; k < 8; k++) begin
      @(clk_ext); #1;
      if (clk_ctl !== 1'b0) errs++;
    end
    check(errs == 0, "R5 bypass path off", errs, 0);
    @(negedge clk_src);
    byp = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_src);
    t_reset();
    rst_n = 1'b1;
    for (int c = 1; c < 8; c++) t_ratio(c);
    t_pass();
    t_ignore_sel();
    t_enable_off();
    t_bypass();
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule